// File: doc/BRIEF.md
# Stack-Relative Register Address Generator

This block turns the three 8-bit register specifiers of an instruction into physical row numbers for a 192-entry register file. The three specifiers are two source operands and one destination. Specifiers whose top bit is clear name one of 64 global rows by absolute number. Specifiers whose top bit is set name one of 128 local rows, counted from a runtime stack pointer. The stack pointer is the contents of global row 1, which the surrounding datapath supplies on a port.

A specifier equal to zero is an indirect access. The port then takes its specifier from its own pointer value, one pointer per operand slot, and translates that pointer value by the same rules. Any mix of the three slots may be indirect in one instruction. After translation, each final row number is checked against a 12-bit bank protection mask. In user mode, a hit in a protected bank raises a trap for that slot.

The outputs are registered. Results appear one clock after the operation is presented.

Top module: `rsg_regaddr_gen`

## Requirements
- R1: A direct specifier in 1..63 yields a row index equal to the specifier, and every index produced lies in 0..191.
- R2: A specifier with bit 7 set yields index 64 + ((specifier[6:0] + stack_ptr[8:2]) mod 128), wrapping within the local rows.
- R3: Only bits [8:2] of `stack_ptr` affect translation; changing its other bits leaves every output unchanged.
- R4: A specifier of 0 on a slot replaces that slot's specifier with its own pointer input (`ptr_a`, `ptr_b`, `ptr_c`), independently per slot.
- R5: A pointer value is translated by the R1/R2/R6 rules. A pointer value of 0 is illegal: the slot's illegal flag is set and its index is 0.
- R6: A global specifier in 64..127, direct or taken from a pointer, is illegal: the slot's illegal flag is 1, its index is 0 and it never traps.
- R7: In user mode (`user_mode`=1), a legal slot traps when `prot_mask[index/16]` is 1. Bit n of the mask covers rows 16n..16n+15.
- R8: With `user_mode`=0, no slot ever traps, whatever the mask.
- R9: Results for an operation sampled with `op_valid`=1 appear on the outputs one clock later with `out_valid`=1. After a cycle without `op_valid`, `out_valid`, the illegal flags and the traps are 0, and the indices keep their last values.
- R10: While reset is asserted, all indices, flags, traps and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An instruction's specifiers are presented this cycle |
| user_mode | input | 1 | 1 = user access, subject to protection |
| spec_a | input | 8 | First source specifier |
| spec_b | input | 8 | Second source specifier |
| spec_c | input | 8 | Destination specifier |
| ptr_a | input | 8 | Indirect pointer for the first source |
| ptr_b | input | 8 | Indirect pointer for the second source |
| ptr_c | input | 8 | Indirect pointer for the destination |
| stack_ptr | input | 32 | Contents of global row 1 |
| prot_mask | input | 12 | One protect bit per 16-row bank |
| out_valid | output | 1 | Registered results are valid |
| idx_a | output | 8 | Physical row for the first source |
| idx_b | output | 8 | Physical row for the second source |
| idx_c | output | 8 | Physical row for the destination |
| illegal | output | 3 | Per-slot illegal-register flag (bit 0 = a, 1 = b, 2 = c) |
| prot_trap | output | 3 | Per-slot protection trap (bit 0 = a, 1 = b, 2 = c) |

## Verification
Every result sits behind exactly one register, so each index, illegal flag and trap is due on the first rising edge after the inputs are applied. The bench applies inputs on a falling edge and compares the outputs on the following falling edge, half a period after the capturing edge. An idle cycle is checked the same way, one falling edge after `op_valid` drops, with the indices compared against the previous vector's values.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int DEF_SPEC_W     = 8;
  localparam int DEF_NUM_GLOBAL = 64;
  localparam int DEF_NUM_LOCAL  = 128;
  localparam int DEF_BANK_SIZE  = 16;
  localparam int DEF_SP_W       = 32;
  localparam int DEF_SP_LSB     = 2;

  // operand slot numbering; also the bit order of the per-slot flag vectors
  typedef enum int {
    SLOT_SRC_A = 0,
    SLOT_SRC_B = 1,
    SLOT_DST   = 2
  } slot_e;

  localparam int NUM_SLOTS = 3;
endpackage

// File: rtl/rsg_slot_xlate.sv
module rsg_slot_xlate #(
  parameter int SPEC_W     = 8,
  parameter int NUM_GLOBAL = 64,
  parameter int NUM_LOCAL  = 128,
  parameter int IDX_W      = 8,
  parameter int LOC_W      = 7
) (
  input  logic [SPEC_W-1:0] spec,
  input  logic [SPEC_W-1:0] ptr,
  input  logic [LOC_W-1:0]  sp_field,
  output logic [IDX_W-1:0]  idx,
  output logic              illegal,
  output logic              indirect,
  output logic              local_sel
);
  // returns {illegal, index}
  function automatic logic [IDX_W:0] xlate(input logic [SPEC_W-1:0] s,
                                           input logic [LOC_W-1:0]  spf);
    logic [LOC_W-1:0] off;
    logic [IDX_W:0]   r;
    off = s[LOC_W-1:0] + spf;
    if (s[SPEC_W-1]) begin
      r = {1'b0, IDX_W'(NUM_GLOBAL) + IDX_W'(off)};
    end else if ((s == '0) || (s >= SPEC_W'(NUM_GLOBAL))) begin
      r = {1'b1, {IDX_W{1'b0}}};
    end else begin
      r = {1'b0, IDX_W'(s)};
    end
    return r;
  endfunction

  logic [SPEC_W-1:0] eff_spec;
  logic [IDX_W:0]    res;

  always_comb begin
    indirect  = (spec == '0);
    eff_spec  = indirect ? ptr : spec;
    local_sel = eff_spec[SPEC_W-1];
    res       = xlate(eff_spec, sp_field);
    illegal   = res[IDX_W];
    idx       = res[IDX_W-1:0];
  end
endmodule

// File: rtl/rsg_bank_guard.sv
module rsg_bank_guard #(
  parameter int IDX_W     = 8,
  parameter int NUM_BANKS = 12,
  parameter int BANK_SIZE = 16
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic                 illegal,
  input  logic                 user_mode,
  input  logic [NUM_BANKS-1:0] prot_mask,
  output logic                 bank_hit,
  output logic                 trap
);
  localparam int BSH = $clog2(BANK_SIZE);

  always_comb begin
    bank_hit = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(idx >> BSH) == b) bank_hit = prot_mask[b];
    end
    trap = user_mode && !illegal && bank_hit;
  end
endmodule

// File: rtl/rsg_regaddr_gen.sv
module rsg_regaddr_gen
  import rsg_pkg::*;
#(
  parameter int SPEC_W     = DEF_SPEC_W,
  parameter int NUM_GLOBAL = DEF_NUM_GLOBAL,
  parameter int NUM_LOCAL  = DEF_NUM_LOCAL,
  parameter int BANK_SIZE  = DEF_BANK_SIZE,
  parameter int SP_W       = DEF_SP_W,
  parameter int SP_LSB     = DEF_SP_LSB,
  localparam int NUM_REGS  = NUM_GLOBAL + NUM_LOCAL,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int NUM_BANKS = NUM_REGS / BANK_SIZE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic                 user_mode,
  input  logic [SPEC_W-1:0]    spec_a,
  input  logic [SPEC_W-1:0]    spec_b,
  input  logic [SPEC_W-1:0]    spec_c,
  input  logic [SPEC_W-1:0]    ptr_a,
  input  logic [SPEC_W-1:0]    ptr_b,
  input  logic [SPEC_W-1:0]    ptr_c,
  input  logic [SP_W-1:0]      stack_ptr,
  input  logic [NUM_BANKS-1:0] prot_mask,
  output logic                 out_valid,
  output logic [IDX_W-1:0]     idx_a,
  output logic [IDX_W-1:0]     idx_b,
  output logic [IDX_W-1:0]     idx_c,
  output logic [NUM_SLOTS-1:0] illegal,
  output logic [NUM_SLOTS-1:0] prot_trap
);
  localparam int LOC_W = $clog2(NUM_LOCAL);

  logic [LOC_W-1:0]  sp_field;
  logic              sp_unused;
  logic [SPEC_W-1:0] spec_arr [NUM_SLOTS];
  logic [SPEC_W-1:0] ptr_arr  [NUM_SLOTS];

  // combinational per-slot results, named for the checker
  logic [IDX_W-1:0]     slot_idx [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_illegal;
  logic [NUM_SLOTS-1:0] slot_indirect;
  logic [NUM_SLOTS-1:0] slot_local;
  logic [NUM_SLOTS-1:0] slot_bank_hit;
  logic [NUM_SLOTS-1:0] slot_trap;

  logic [IDX_W-1:0] idx_q [NUM_SLOTS];

  assign sp_field  = stack_ptr[SP_LSB+LOC_W-1:SP_LSB];
  assign sp_unused = ^{stack_ptr[SP_W-1:SP_LSB+LOC_W], stack_ptr[SP_LSB-1:0]};

  assign spec_arr[SLOT_SRC_A] = spec_a;
  assign spec_arr[SLOT_SRC_B] = spec_b;
  assign spec_arr[SLOT_DST]   = spec_c;
  assign ptr_arr[SLOT_SRC_A]  = ptr_a;
  assign ptr_arr[SLOT_SRC_B]  = ptr_b;
  assign ptr_arr[SLOT_DST]    = ptr_c;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    rsg_slot_xlate #(
      .SPEC_W    (SPEC_W),
      .NUM_GLOBAL(NUM_GLOBAL),
      .NUM_LOCAL (NUM_LOCAL),
      .IDX_W     (IDX_W),
      .LOC_W     (LOC_W)
    ) xlate_i (
      .spec     (spec_arr[s]),
      .ptr      (ptr_arr[s]),
      .sp_field (sp_field),
      .idx      (slot_idx[s]),
      .illegal  (slot_illegal[s]),
      .indirect (slot_indirect[s]),
      .local_sel(slot_local[s])
    );

    rsg_bank_guard #(
      .IDX_W    (IDX_W),
      .NUM_BANKS(NUM_BANKS),
      .BANK_SIZE(BANK_SIZE)
    ) guard_i (
      .idx      (slot_idx[s]),
      .illegal  (slot_illegal[s]),
      .user_mode(user_mode),
      .prot_mask(prot_mask),
      .bank_hit (slot_bank_hit[s]),
      .trap     (slot_trap[s])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_q[s] <= '0;
      end else if (op_valid) begin
        idx_q[s] <= slot_idx[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      illegal   <= '0;
      prot_trap <= '0;
    end else begin
      out_valid <= op_valid;
      illegal   <= op_valid ? slot_illegal : '0;
      prot_trap <= op_valid ? slot_trap : '0;
    end
  end

  assign idx_a = idx_q[SLOT_SRC_A];
  assign idx_b = idx_q[SLOT_SRC_B];
  assign idx_c = idx_q[SLOT_DST];
endmodule

// File: rtl/rsg_regaddr_chk.sv
module rsg_regaddr_chk #(
  parameter int SPEC_W    = 8,
  parameter int IDX_W     = 8,
  parameter int NUM_REGS  = 192,
  parameter int NUM_GLOBAL = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              user_mode,
  input logic [SPEC_W-1:0] spec_a,
  input logic              out_valid,
  input logic [IDX_W-1:0]  idx_a,
  input logic [IDX_W-1:0]  idx_b,
  input logic [IDX_W-1:0]  idx_c,
  input logic [2:0]        illegal,
  input logic [2:0]        prot_trap
);
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(idx_a) < NUM_REGS && int'(idx_b) < NUM_REGS && int'(idx_c) < NUM_REGS)); // R1

  AST_DIRECT_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && spec_a != '0 && spec_a < SPEC_W'(NUM_GLOBAL)) |=> (idx_a == IDX_W'($past(spec_a)))); // R1

  AST_ILLEGAL_NO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal[0]) |-> (idx_a == '0 && !prot_trap[0])); // R6

  AST_SUPERVISOR_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !user_mode) |=> (prot_trap == '0)); // R8

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> out_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!out_valid && illegal == '0 && prot_trap == '0)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !op_valid) |=> ($stable(idx_a) && $stable(idx_b) && $stable(idx_c))); // R9
endmodule

bind rsg_regaddr_gen rsg_regaddr_chk #(
  .SPEC_W    (SPEC_W),
  .IDX_W     (IDX_W),
  .NUM_REGS  (NUM_REGS),
  .NUM_GLOBAL(NUM_GLOBAL)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .user_mode(user_mode),
  .spec_a   (spec_a),
  .out_valid(out_valid),
  .idx_a    (idx_a),
  .idx_b    (idx_b),
  .idx_c    (idx_c),
  .illegal  (illegal),
  .prot_trap(prot_trap)
);

// File: tb/rsg_regaddr_gen_tb.sv
module rsg_regaddr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        user_mode = 1'b0;
  logic [7:0]  spec_a = '0, spec_b = '0, spec_c = '0;
  logic [7:0]  ptr_a = '0, ptr_b = '0, ptr_c = '0;
  logic [31:0] stack_ptr = '0;
  logic [11:0] prot_mask = '0;
  logic        out_valid;
  logic [7:0]  idx_a, idx_b, idx_c;
  logic [2:0]  illegal, prot_trap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsg_regaddr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .user_mode(user_mode),
    .spec_a(spec_a), .spec_b(spec_b), .spec_c(spec_c),
    .ptr_a(ptr_a), .ptr_b(ptr_b), .ptr_c(ptr_c),
    .stack_ptr(stack_ptr), .prot_mask(prot_mask),
    .out_valid(out_valid), .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
    .illegal(illegal), .prot_trap(prot_trap)
  );

  // reference: returns {trap, illegal, index[7:0]}
  function automatic logic [9:0] ref_slot(input logic [7:0] s, input logic [7:0] p,
                                          input logic [31:0] sp, input logic user,
                                          input logic [11:0] mask);
    logic [7:0] e;
    int         row;
    bit         bad;
    bit         tr;
    e   = (s == 8'd0) ? p : s;
    bad = 0;
    row = 0;
    if (e >= 8'd128) row = 64 + ((int'(e) - 128 + int'(sp[8:2])) % 128);
    else if (e == 8'd0 || e >= 8'd64) bad = 1;
    else row = int'(e);
    tr = user && !bad && mask[row / 16];
    return {tr, bad, row[7:0]};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // apply on a falling edge, compare on the next falling edge
  task automatic apply(input string req,
                       input logic [7:0] sa, input logic [7:0] sb, input logic [7:0] sc,
                       input logic [7:0] pa, input logic [7:0] pb, input logic [7:0] pc,
                       input logic [31:0] sp, input logic user, input logic [11:0] mask);
    logic [9:0] ea, eb, ec;
    spec_a = sa; spec_b = sb; spec_c = sc;
    ptr_a = pa; ptr_b = pb; ptr_c = pc;
    stack_ptr = sp; user_mode = user; prot_mask = mask; op_valid = 1'b1;
    ea = ref_slot(sa, pa, sp, user, mask);
    eb = ref_slot(sb, pb, sp, user, mask);
    ec = ref_slot(sc, pc, sp, user, mask);
    @(negedge clk);
    check(req, "valid", int'(out_valid), 1);
    check(req, "idx_a", int'(idx_a), int'(ea[7:0]));
    check(req, "idx_b", int'(idx_b), int'(eb[7:0]));
    check(req, "idx_c", int'(idx_c), int'(ec[7:0]));
    check(req, "illegal", int'(illegal), int'({ec[8], eb[8], ea[8]}));
    check(req, "trap", int'(prot_trap), int'({ec[9], eb[9], ea[9]}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ha, hb, hc;
    void'($urandom(32'h29A5_0C11));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "valid", int'(out_valid), 0);
    check("R10", "idx", int'({idx_a, idx_b, idx_c}), 0);
    check("R10", "flags", int'({illegal, prot_trap}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: direct globals
    apply("R1", 8'd1, 8'd2, 8'd63, 8'd0, 8'd0, 8'd0, 32'h0, 1'b0, 12'h000);
    apply("R1", 8'd17, 8'd40, 8'd5, 8'd9, 8'd9, 8'd9, 32'hFFFF_FFFF, 1'b1, 12'h000);
    // R2: local, plain and wrapping (0xFF + 1 -> row 64; 0x80 + 127 -> row 191)
    apply("R2", 8'hFF, 8'h80, 8'hC0, 8'd0, 8'd0, 8'd0, 32'h0000_0004, 1'b0, 12'h000);
    apply("R2", 8'h80, 8'h81, 8'hFF, 8'd0, 8'd0, 8'd0, 32'h0000_01FC, 1'b0, 12'h000);
    // R3: bits outside [8:2] of the stack pointer have no effect
    apply("R3", 8'h85, 8'hA0, 8'hF3, 8'd0, 8'd0, 8'd0, 32'h0000_0028, 1'b0, 12'h000);
    apply("R3", 8'h85, 8'hA0, 8'hF3, 8'd0, 8'd0, 8'd0, 32'hABCD_FE2B, 1'b0, 12'h000);
    // R4: each slot indirect on its own pointer
    apply("R4", 8'd0, 8'd7, 8'd7, 8'd12, 8'd50, 8'd60, 32'h0, 1'b0, 12'h000);
    apply("R4", 8'd0, 8'd0, 8'd0, 8'd33, 8'h90, 8'd3, 32'h0000_0010, 1'b0, 12'h000);
    // R5: pointer value 0 is illegal; pointer into unimplemented range too
    apply("R5", 8'd0, 8'd0, 8'd4, 8'd0, 8'd100, 8'd0, 32'h0, 1'b1, 12'hFFF);
    // R6: unimplemented globals, never trapping
    apply("R6", 8'd64, 8'd127, 8'd99, 8'd0, 8'd0, 8'd0, 32'h0, 1'b1, 12'hFFF);
    // R7: bank edges; bank 0 (row 15), bank 4 (row 64), bank 11 (row 191)
    apply("R7", 8'd15, 8'd16, 8'h80, 8'd0, 8'd0, 8'd0, 32'h0, 1'b1, 12'h011);
    apply("R7", 8'h80, 8'hBF, 8'd0, 8'd0, 8'd0, 8'hFF, 32'h0000_0100, 1'b1, 12'h800);
    // R8: supervisor never traps
    apply("R8", 8'd15, 8'h80, 8'd0, 8'd0, 8'd0, 8'd2, 32'h0, 1'b0, 12'hFFF);

    // R9: idle cycle clears flags and valid, indices hold
    apply("R9", 8'd9, 8'h83, 8'd64, 8'd0, 8'd0, 8'd0, 32'h0, 1'b1, 12'hFFF);
    ha = idx_a; hb = idx_b; hc = idx_c;
    op_valid = 1'b0; spec_a = 8'd30; spec_b = 8'd0; spec_c = 8'd64;
    @(negedge clk);
    check("R9", "idle valid", int'(out_valid), 0);
    check("R9", "idle flags", int'({illegal, prot_trap}), 0);
    check("R9", "idle hold", int'({idx_a, idx_b, idx_c}), int'({ha, hb, hc}));

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ra, rb, rc;
      ra = ($urandom % 6 == 0) ? 8'd0 : 8'($urandom);
      rb = ($urandom % 6 == 0) ? 8'd0 : 8'($urandom);
      rc = ($urandom % 6 == 0) ? 8'd0 : 8'($urandom);
      apply("R7", ra, rb, rc, 8'($urandom), 8'($urandom), 8'($urandom),
            $urandom, 1'($urandom), 12'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule